// File: doc/BRIEF.md
# Masked Register Profile Streamer

This block applies one of several stored configuration profiles to a bank of 8-bit configuration registers. It reaches those registers through a memory-mapped master port. Each profile is a list of entries held in an on-chip table. An entry names one register, a mask of the bits it owns, and the new values for those bits. For each entry the streamer reads the register, replaces only the masked bits, and writes the merged byte back. It then moves to the next entry. Entries are applied strictly in table order, so several entries that hit one register build on each other.

Software drives the block through a small slave port. A control register selects a profile and launches a run. A status register shows whether a run is in progress and holds a sticky error flag. When a run finishes, the block raises a one-cycle request that a downstream calibration engine can use to retune the channel.

Top module: `cfg_profile_streamer`

## Requirements
- R1: After reset: no master request is active, `recalReq` is 0, the status register reads 0x00, and the control register reads back the power-up default profile (parameter `DEFAULT_PROF`, 3 by default).
- R2: A table entry is 35 bits: [34:16] register address, [15:8] mask, [7:0] value. The byte written is (readback AND NOT mask) OR (value AND mask), so unmasked bits keep their readback value.
- R3: Entries are processed in ascending slot order, each as one read followed by one write to the entry's address. A read always returns the effect of all earlier writes, including writes to the same address within the same run. No master access happens outside a run.
- R4: Profile p owns slots 0..7. Slots k <= p hold real entries: address 0x230 + (k mod 3), mask bits (p+k) mod 8 and (p+2k+3) mod 8 set, value 0x5A XOR (8p+k). Any other slot is a terminator with mask 0x00. A run stops before any terminator, or after slot 7.
- R5: Control register 0x40140: bits [5:0] select the profile and bit 7 = 1 launches a run. A valid write made while idle updates the selection, even when bit 7 is 0. A read returns the selection in bits [5:0], with bits 7:6 reading 0.
- R6: Status register 0x40141 bit 0 is 1 from the cycle after a launch until the run completes, and 0 otherwise.
- R7: `recalReq` is high for exactly one cycle, in the cycle after the last write is accepted. That cycle is the final busy cycle.
- R8: The master holds `mRead` or `mWrite`, with address and write data stable, until `mWaitReq` is low. The write for an entry is issued only after `mRdValid`. Read and write are never asserted together.
- R9: A control write whose bits [5:0] are 8 or more is ignored: no run starts and the selection is unchanged. Such a write sets status bit 1.
- R10: A launch written while busy is ignored and sets status bit 1. Status bit 1 stays set until reset.
- R11: Slave reads return data on `csrRdData` in the cycle after `csrRead`. Unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csrAddr | input | 19 | Slave word address |
| csrWrite | input | 1 | Slave write strobe |
| csrWrData | input | 8 | Slave write data |
| csrRead | input | 1 | Slave read strobe |
| csrRdData | output | 8 | Slave read data, registered |
| mAddr | output | 19 | Master register address |
| mRead | output | 1 | Master read request |
| mWrite | output | 1 | Master write request |
| mWrData | output | 8 | Master write data |
| mRdData | input | 8 | Master read data |
| mRdValid | input | 1 | Master read data valid |
| mWaitReq | input | 1 | Master stall, request not yet accepted |
| recalReq | output | 1 | One-cycle recalibration request at run end |

## Verification
The embedded properties check, on every cycle, the master handshake rules and the read/write exclusion. They also confirm that no access is made to a terminator slot, that the recalibration pulse is followed at once by idle, that busy only falls after that pulse, and that the error flag never clears. The merged data, the address order, the accumulation across repeated addresses, the slot-7 region end, and the handling of ignored control writes can only be shown by the bench's scenarios. In those scenarios a behavioural memory and table model predict every write under several stall and latency patterns.

// File: rtl/cps_pkg.sv
`timescale 1ns/1ps
package cps_pkg;
  localparam int REG_ADDR_W = 19;
  localparam int REG_DATA_W = 8;

  typedef struct packed {
    logic [REG_ADDR_W-1:0] addr;
    logic [REG_DATA_W-1:0] mask;
    logic [REG_DATA_W-1:0] value;
  } entry_t;

  // strobes from control to datapath
  typedef struct packed {
    logic startRun;
    logic captureRead;
    logic advance;
  } dpCtl_t;

  // synthesizable table image: profile p, slot k
  function automatic entry_t romImage(input int p, input int k);
    entry_t e;
    e = '0;
    if (k <= p) begin
      e.addr  = REG_ADDR_W'(32'h230 + (k % 3));
      e.mask  = REG_DATA_W'(1 << ((p + k) % 8)) | REG_DATA_W'(1 << ((p + 2*k + 3) % 8));
      e.value = REG_DATA_W'(32'h5A ^ (8*p + k));
    end
    return e;
  endfunction
endpackage

// File: rtl/cps_datapath.sv
`timescale 1ns/1ps
module cps_datapath
  import cps_pkg::*;
#(
  parameter int NUM_PROF = 8,
  parameter int SLOTS    = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  dpCtl_t                            ctl,
  input  logic [((NUM_PROF>1)?$clog2(NUM_PROF):1)-1:0] runProf,
  input  logic [REG_DATA_W-1:0]             rdData,
  output logic [REG_ADDR_W-1:0]             entAddr,
  output logic [REG_DATA_W-1:0]             wrData,
  output logic                              curTerm,
  output logic                              lastEntry
);
  localparam int PROF_W = (NUM_PROF > 1) ? $clog2(NUM_PROF) : 1;
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int DEPTH  = NUM_PROF * SLOTS;
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  entry_t rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign rom[i] = romImage(i / SLOTS, i % SLOTS);
  end

  logic [PROF_W-1:0]     profReg;
  logic [SLOT_W-1:0]     slot;
  logic [REG_DATA_W-1:0] merged;
  logic [IDX_W-1:0]      curIdx;
  logic [IDX_W-1:0]      nextIdx;
  logic                  atRegionEnd;
  entry_t                cur;

  assign curIdx      = IDX_W'(profReg) * IDX_W'(SLOTS) + IDX_W'(slot);
  assign nextIdx     = curIdx + IDX_W'(1);
  assign cur         = rom[curIdx];
  assign atRegionEnd = (slot == SLOT_W'(SLOTS - 1));
  assign curTerm     = (cur.mask == '0);
  assign lastEntry   = atRegionEnd ? 1'b1 : (rom[nextIdx].mask == '0);
  assign entAddr     = cur.addr;
  assign wrData      = merged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      profReg <= '0;
      slot    <= '0;
      merged  <= '0;
    end else begin
      if (ctl.startRun) begin
        profReg <= runProf;
        slot    <= '0;
      end else if (ctl.advance) begin
        slot <= slot + SLOT_W'(1);
      end
      if (ctl.captureRead)
        merged <= (rdData & ~cur.mask) | (cur.value & cur.mask);
    end
  end

  // R2: bits outside the mask come straight from the readback
  a_r2_unmasked_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.captureRead |=> (((wrData ^ $past(rdData)) & ~$past(cur.mask)) == '0));
endmodule

// File: rtl/cps_ctrl.sv
`timescale 1ns/1ps
module cps_ctrl
  import cps_pkg::*;
#(
  parameter int                  NUM_PROF     = 8,
  parameter int                  DEFAULT_PROF = 3,
  parameter logic [REG_ADDR_W-1:0] CTRL_ADDR  = 19'h40140,
  parameter logic [REG_ADDR_W-1:0] STAT_ADDR  = 19'h40141
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [REG_ADDR_W-1:0] csrAddr,
  input  logic                  csrWrite,
  input  logic [7:0]            csrWrData,
  input  logic                  csrRead,
  output logic [7:0]            csrRdData,
  input  logic                  mWaitReq,
  input  logic                  mRdValid,
  input  logic                  curTerm,
  input  logic                  lastEntry,
  output logic                  mRead,
  output logic                  mWrite,
  output logic                  recalReq,
  output dpCtl_t                dpCtl,
  output logic [((NUM_PROF>1)?$clog2(NUM_PROF):1)-1:0] runProf
);
  localparam int PROF_W = (NUM_PROF > 1) ? $clog2(NUM_PROF) : 1;

  typedef enum logic [2:0] {S_IDLE, S_SCAN, S_RD, S_RDW, S_WR, S_DONE} state_t;

  state_t            state, stateNext;
  logic [PROF_W-1:0] profSel;
  logic              errFlag;
  logic              busyInt;
  logic              wrCtrl;
  logic              launchBit;
  logic              profOk;
  logic              launchOk;
  logic              unusedWrBit;

  assign unusedWrBit = csrWrData[6];
  assign busyInt     = (state != S_IDLE);
  assign wrCtrl      = csrWrite && (csrAddr == CTRL_ADDR);
  assign launchBit   = csrWrData[7];
  assign profOk      = ({1'b0, csrWrData[5:0]} < 7'(NUM_PROF));
  assign launchOk    = wrCtrl && launchBit && profOk && !busyInt;
  assign runProf     = csrWrData[PROF_W-1:0];
  assign mRead       = (state == S_RD);
  assign mWrite      = (state == S_WR);
  assign recalReq    = (state == S_DONE);

  always_comb begin
    stateNext = state;
    dpCtl     = '0;
    case (state)
      S_IDLE: if (launchOk) begin
        dpCtl.startRun = 1'b1;
        stateNext      = S_SCAN;
      end
      S_SCAN: stateNext = curTerm ? S_DONE : S_RD;
      S_RD:   if (!mWaitReq) stateNext = S_RDW;
      S_RDW:  if (mRdValid) begin
        dpCtl.captureRead = 1'b1;
        stateNext         = S_WR;
      end
      S_WR:   if (!mWaitReq) begin
        dpCtl.advance = 1'b1;
        stateNext     = lastEntry ? S_DONE : S_RD;
      end
      S_DONE: stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      profSel   <= PROF_W'(DEFAULT_PROF);
      errFlag   <= 1'b0;
      csrRdData <= '0;
    end else begin
      state <= stateNext;
      if (wrCtrl && !busyInt && profOk)
        profSel <= csrWrData[PROF_W-1:0];
      if (wrCtrl && ((busyInt && launchBit) || (!busyInt && !profOk)))
        errFlag <= 1'b1;
      if (csrRead) begin
        if (csrAddr == CTRL_ADDR)      csrRdData <= 8'(profSel);
        else if (csrAddr == STAT_ADDR) csrRdData <= {6'b0, errFlag, busyInt};
        else                           csrRdData <= '0;
      end else begin
        csrRdData <= '0;
      end
    end
  end

  // R7: the request pulse is the final busy cycle
  a_r7_recal_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    recalReq |=> (!recalReq && state == S_IDLE));
  // R6: busy only drops right after the request pulse
  a_r6_busy_falls_after_recal: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busyInt) |-> $past(recalReq));
  // R10: error flag is sticky
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    errFlag |=> errFlag);
  // R9: an out-of-range profile never starts a run
  a_r9_bad_prof_no_run: assert property (@(posedge clk) disable iff (!rst_n)
    (!busyInt && wrCtrl && !profOk) |=> (state == S_IDLE));
endmodule

// File: rtl/cfg_profile_streamer.sv
`timescale 1ns/1ps
module cfg_profile_streamer
  import cps_pkg::*;
#(
  parameter int                    NUM_PROF     = 8,
  parameter int                    SLOTS        = 8,
  parameter int                    DEFAULT_PROF = 3,
  parameter logic [REG_ADDR_W-1:0] CTRL_ADDR    = 19'h40140,
  parameter logic [REG_ADDR_W-1:0] STAT_ADDR    = 19'h40141
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [18:0] csrAddr,
  input  logic        csrWrite,
  input  logic [7:0]  csrWrData,
  input  logic        csrRead,
  output logic [7:0]  csrRdData,
  output logic [18:0] mAddr,
  output logic        mRead,
  output logic        mWrite,
  output logic [7:0]  mWrData,
  input  logic [7:0]  mRdData,
  input  logic        mRdValid,
  input  logic        mWaitReq,
  output logic        recalReq
);
  localparam int PROF_W = (NUM_PROF > 1) ? $clog2(NUM_PROF) : 1;

  dpCtl_t            dpCtl;
  logic [PROF_W-1:0] runProf;
  logic              curTerm;
  logic              lastEntry;

  cps_ctrl #(
    .NUM_PROF(NUM_PROF), .DEFAULT_PROF(DEFAULT_PROF),
    .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .csrAddr(csrAddr), .csrWrite(csrWrite), .csrWrData(csrWrData),
    .csrRead(csrRead), .csrRdData(csrRdData),
    .mWaitReq(mWaitReq), .mRdValid(mRdValid),
    .curTerm(curTerm), .lastEntry(lastEntry),
    .mRead(mRead), .mWrite(mWrite), .recalReq(recalReq),
    .dpCtl(dpCtl), .runProf(runProf)
  );

  cps_datapath #(.NUM_PROF(NUM_PROF), .SLOTS(SLOTS)) dp_i (
    .clk(clk), .rst_n(rst_n), .ctl(dpCtl), .runProf(runProf),
    .rdData(mRdData), .entAddr(mAddr), .wrData(mWrData),
    .curTerm(curTerm), .lastEntry(lastEntry)
  );

  // R8: requests held stable while stalled
  a_r8_read_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mRead && mWaitReq) |=> (mRead && $stable(mAddr)));
  a_r8_write_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mWrite && mWaitReq) |=> (mWrite && $stable(mAddr) && $stable(mWrData)));
  a_r8_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mRead && mWrite));
  // R4: a terminator slot is never accessed
  a_r4_no_term_access: assert property (@(posedge clk) disable iff (!rst_n)
    (mRead || mWrite) |-> !curTerm);
endmodule

// File: tb/cfg_profile_streamer_tb_top.sv
`timescale 1ns/1ps
module cfg_profile_streamer_tb_top;
  localparam int CTRL = 'h40140;
  localparam int STAT = 'h40141;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [18:0] csrAddr = '0;
  logic        csrWrite = 1'b0;
  logic [7:0]  csrWrData = '0;
  logic        csrRead = 1'b0;
  logic [7:0]  csrRdData;
  logic [18:0] mAddr;
  logic        mRead, mWrite;
  logic [7:0]  mWrData;
  logic [7:0]  mRdData = '0;
  logic        mRdValid = 1'b0;
  logic        mWaitReq = 1'b0;
  logic        recalReq;

  cfg_profile_streamer dut_i (
    .clk(clk), .rst_n(rst_n),
    .csrAddr(csrAddr), .csrWrite(csrWrite), .csrWrData(csrWrData),
    .csrRead(csrRead), .csrRdData(csrRdData),
    .mAddr(mAddr), .mRead(mRead), .mWrite(mWrite), .mWrData(mWrData),
    .mRdData(mRdData), .mRdValid(mRdValid), .mWaitReq(mWaitReq),
    .recalReq(recalReq)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int waitMode = 0;
  bit expActive = 0;
  bit recalDue = 0;
  int pendCnt = 0;
  int pendAddr = 0;
  bit heldRd = 0;
  bit heldWr = 0;
  logic [18:0] heldAddr;
  logic [7:0]  heldData;
  logic [7:0] mem [int];
  int qa[$];
  logic [7:0] qd[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] memGet(input int a);
    if (mem.exists(a)) return mem[a];
    return 8'(a) ^ 8'hC3;
  endfunction

  // table model taken from the requirement text
  function automatic void tblEntry(input int p, input int k, output int a,
                                   output logic [7:0] m, output logic [7:0] v);
    a = 'h230 + (k % 3);
    m = (8'd1 << ((p + k) % 8)) | (8'd1 << ((p + 2*k + 3) % 8));
    v = 8'h5A ^ 8'(8*p + k);
  endfunction

  function automatic bit stallNow(input int c);
    case (waitMode)
      1: return (c % 3) != 0;
      2: return (c % 4) == 1;
      default: return 1'b0;
    endcase
  endfunction

  // cycle-by-cycle master-side model
  always @(negedge clk) begin
    bit w;
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (recalDue) begin
      chk(recalReq === 1'b1, "R7", "recal pulse", recalReq, 1);
      recalDue = 0;
      expActive = 0;
    end else begin
      chk(recalReq === 1'b0, "R7", "recal idle", recalReq, 0);
    end
    if (!expActive)
      chk(!(mRead || mWrite), "R3", "access outside run", {mRead, mWrite}, 0);
    chk(!(mRead && mWrite), "R8", "rd and wr together", {mRead, mWrite}, 0);
    if (heldRd) chk(mRead && mAddr == heldAddr, "R8", "read not held", mAddr, heldAddr);
    if (heldWr) chk(mWrite && mAddr == heldAddr && mWrData == heldData, "R8",
                    "write not held", mWrData, heldData);
    mRdValid = 1'b0;
    if (pendCnt > 0) begin
      pendCnt--;
      if (pendCnt == 0) begin
        mRdValid = 1'b1;
        mRdData  = memGet(pendAddr);
      end
    end
    w = stallNow(cyc);
    mWaitReq = w;
    heldRd = mRead && w;
    heldWr = mWrite && w;
    heldAddr = mAddr;
    heldData = mWrData;
    if (mRead && !w) begin
      chk(qa.size() > 0 && int'(mAddr) == qa[0], "R3", "read address",
          mAddr, (qa.size() > 0) ? qa[0] : -1);
      pendAddr = int'(mAddr);
      pendCnt  = 1 + (cyc % 3);
    end
    if (mWrite && !w) begin
      if (qa.size() == 0) begin
        chk(0, "R3", "unexpected write", mAddr, 0);
      end else begin
        chk(int'(mAddr) == qa[0], "R3", "write address", mAddr, qa[0]);
        chk(mWrData == qd[0], "R2", "merged data", mWrData, qd[0]);
        mem[int'(mAddr)] = mWrData;
        void'(qa.pop_front());
        void'(qd.pop_front());
        if (qa.size() == 0) recalDue = 1;
      end
    end
  end

  task automatic csrWr(input int a, input logic [7:0] d, input bit starts);
    @(negedge clk);
    csrAddr = 19'(a); csrWrData = d; csrWrite = 1'b1;
    @(posedge clk);
    #1;
    if (starts) expActive = 1;
    @(negedge clk);
    csrWrite = 1'b0;
  endtask

  task automatic csrRd(input int a, output logic [7:0] d);
    @(negedge clk);
    csrAddr = 19'(a); csrRead = 1'b1;
    @(posedge clk);
    @(negedge clk);
    csrRead = 1'b0;
    d = csrRdData;
  endtask

  task automatic launch(input int p, input int mode);
    logic [7:0] shadow [int];
    waitMode = mode;
    for (int k = 0; k < 8; k++) begin
      int a; logic [7:0] m, v, cur;
      if (k > p) break;
      tblEntry(p, k, a, m, v);
      cur = shadow.exists(a) ? shadow[a] : memGet(a);
      shadow[a] = (cur & ~m) | (v & m);
      qa.push_back(a);
      qd.push_back(shadow[a]);
    end
    csrWr(CTRL, 8'h80 | 8'(p), 1);
  endtask

  task automatic waitIdle();
    while (expActive) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    expActive = 0; recalDue = 0; pendCnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    csrRd(STAT, d); chk(d == 8'h00, "R1", "status after reset", d, 0);
    csrRd(CTRL, d); chk(d == 8'h03, "R1", "default profile", d, 3);
    chk(!mRead && !mWrite && !recalReq, "R1", "idle outputs", {mRead, mWrite, recalReq}, 0);
    // R2 R3 R7: single-entry profile, no stalls
    launch(0, 0); waitIdle();
    csrRd(STAT, d); chk(d[0] == 1'b0, "R6", "busy clear after run", d, 0);
    // R5: select without launch
    csrWr(CTRL, 8'h05, 0);
    csrRd(CTRL, d); chk(d == 8'h05, "R5", "selection readback", d, 5);
    csrRd(STAT, d); chk(d == 8'h00, "R5", "no run from select", d, 0);
    // R3 accumulation on repeated address, with stalls
    launch(3, 1); waitIdle();
    csrRd(CTRL, d); chk(d == 8'h03, "R5", "launch updates selection", d, 3);
    // R4 region end at slot 7
    launch(7, 2); waitIdle();
    chk(qa.size() == 0, "R4", "all entries of profile 7 applied", qa.size(), 0);
    // R6 busy during run, R10 launch while busy
    launch(5, 1);
    csrRd(STAT, d); chk(d[0] == 1'b1, "R6", "busy during run", d, 1);
    csrWr(CTRL, 8'h81, 0);
    waitIdle();
    csrRd(STAT, d); chk(d == 8'h02, "R10", "error after busy launch", d, 2);
    csrRd(CTRL, d); chk(d == 8'h05, "R10", "selection kept", d, 5);
    launch(2, 0); waitIdle();
    csrRd(STAT, d); chk(d == 8'h02, "R10", "error sticky", d, 2);
    // R11 unmapped read
    csrRd('h40142, d); chk(d == 8'h00, "R11", "unmapped read", d, 0);
    // R9 after fresh reset
    doReset();
    csrRd(CTRL, d); chk(d == 8'h03, "R1", "default after reset", d, 3);
    csrRd(STAT, d); chk(d == 8'h00, "R1", "error cleared by reset", d, 0);
    csrWr(CTRL, 8'h89, 0);
    repeat (6) @(negedge clk);
    csrRd(STAT, d); chk(d == 8'h02, "R9", "error on bad profile", d, 2);
    csrRd(CTRL, d); chk(d == 8'h03, "R9", "selection unchanged", d, 3);
    csrWr(CTRL, 8'h0A, 0);
    csrRd(CTRL, d); chk(d == 8'h03, "R9", "bad select ignored", d, 3);
    launch(1, 2); waitIdle();
    chk(memGet('h230) == mem['h230], "R2", "memory model consistent", memGet('h230), mem['h230]);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule